// File: doc/BRIEF.md
# Configurable Packet CRC Checker

This block checks a 32-bit CRC over a receive packet that arrives one byte per clock. A byte is taken whenever `in_valid` is high. `in_last` marks the final byte of a packet. The next valid byte after a final byte opens a new packet. Each packet carries its own settings:

- the first byte index of the covered region;
- either an explicit last index or a tail mode, in which the region stops one byte before the packet's final byte;
- where the received CRC sits in the packet;
- which of two programmable generator polynomials to use;
- whether each byte is bit-reversed before it is accumulated;
- whether the accumulated value is inverted before the compare.

One cycle after the final byte, the block raises a single-cycle result strobe. With it comes a pass flag and a one-bit status. The status either repeats the CRC verdict or forwards an externally computed checksum status, as chosen per packet.

The settings and the selected polynomial are captured on the first byte of a packet. They are then held until the result of that packet is produced, so upstream logic may change them freely while the packet is still in flight.

Top module: `crc_check`

## Requirements
- R1: After reset, `res_valid`, `res_pass` and `res_status` are 0.
- R2: The CRC is 32 bits wide and processed MSB first (non-reflected). The accumulator starts at all ones. Each covered byte is XORed into bits 31:24 and shifted through 8 steps with the selected polynomial. The received CRC is the 4 bytes starting at byte index `cfg_crc_pos`, most significant byte first. `res_valid` is a one-cycle pulse in the cycle after the `in_last` byte. `res_pass` is 1 when the final value equals the received CRC.
- R3: With `cfg_tail`=0, the covered bytes are those whose index i satisfies `cfg_start` <= i <= `cfg_end`. Bytes outside that range do not affect the result.
- R4: A covered byte whose index lies in `cfg_crc_pos` .. `cfg_crc_pos`+3 is accumulated as 0x00 instead of its value.
- R5: With `cfg_tail`=1, the covered bytes run from `cfg_start` up to the byte before the `in_last` byte, and `cfg_end` is ignored.
- R6: With `cfg_poly_sel`=0 the polynomial is `poly_a`. With `cfg_poly_sel`=1 it is `poly_b`.
- R7: With `cfg_mirror`=1, each covered byte is bit-reversed (bit 0 swaps with bit 7) before it is accumulated.
- R8: With `cfg_invert`=1, the accumulated value is bitwise inverted before the compare.
- R9: With `cfg_stat_sel`=1, `res_status` equals `res_pass`. With `cfg_stat_sel`=0, it equals `csum_ok` as sampled on the `in_last` byte.
- R10: All `cfg_*` inputs and the selected polynomial are sampled on the first byte of a packet. Changes to them during the rest of the packet have no effect.
- R11: If the index of the `in_last` byte is below `cfg_start`, `res_pass` is 0.
- R12: Cycles with `in_valid`=0 inside a packet change neither the result nor the byte indexing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte strobe |
| in_data | input | 8 | Packet byte |
| in_last | input | 1 | Final byte of the packet |
| cfg_start | input | 8 | First covered byte index |
| cfg_end | input | 16 | Last covered byte index (explicit mode) |
| cfg_crc_pos | input | 16 | Index of first received CRC byte |
| cfg_poly_sel | input | 1 | Polynomial choice |
| cfg_mirror | input | 1 | Per-byte bit reversal enable |
| cfg_invert | input | 1 | Final inversion enable |
| cfg_tail | input | 1 | Region ends before final byte |
| cfg_stat_sel | input | 1 | Status source: 1 CRC, 0 checksum |
| poly_a | input | 32 | First polynomial |
| poly_b | input | 32 | Second polynomial |
| csum_ok | input | 1 | External checksum status |
| res_valid | output | 1 | Result strobe |
| res_pass | output | 1 | CRC matched |
| res_status | output | 1 | Selected status |

## Verification
The hardest case to reach is a CRC field that lies inside the covered region. Its bytes must be zeroed, yet they must still be captured as the received value. The sweep builds packets with the field both inside and outside the region. In each case it writes the model's CRC into the field, so a correct design passes. A second copy of the packet with one covered byte corrupted must then fail. Each packet is also sent with idle gaps, and every setting is flipped after the first byte, to show that the captured configuration holds.

// File: rtl/crc_check.sv
module crc_check #(
  parameter int CRC_W = 32,
  parameter int OFS_W = 8,
  parameter int IDX_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_last,
  input  logic [OFS_W-1:0] cfg_start,
  input  logic [IDX_W-1:0] cfg_end,
  input  logic [IDX_W-1:0] cfg_crc_pos,
  input  logic             cfg_poly_sel,
  input  logic             cfg_mirror,
  input  logic             cfg_invert,
  input  logic             cfg_tail,
  input  logic             cfg_stat_sel,
  input  logic [CRC_W-1:0] poly_a,
  input  logic [CRC_W-1:0] poly_b,
  input  logic             csum_ok,
  output logic             res_valid,
  output logic             res_pass,
  output logic             res_status
);
  localparam int NB = CRC_W / 8;

  logic             in_pkt;
  logic [IDX_W-1:0] idx_q, end_q, pos_q;
  logic [OFS_W-1:0] start_q;
  logic             tail_q, mir_q, inv_q, ssel_q;
  logic [CRC_W-1:0] poly_q, crc_q, rx_q;

  wire sop = in_valid & ~in_pkt;

  wire [IDX_W-1:0] idx_c   = sop ? '0 : idx_q;
  wire [IDX_W-1:0] start_c = IDX_W'(sop ? cfg_start : start_q);
  wire [IDX_W-1:0] end_c   = sop ? cfg_end : end_q;
  wire [IDX_W-1:0] pos_c   = sop ? cfg_crc_pos : pos_q;
  wire             tail_c  = sop ? cfg_tail : tail_q;
  wire             mir_c   = sop ? cfg_mirror : mir_q;
  wire             inv_c   = sop ? cfg_invert : inv_q;
  wire             ssel_c  = sop ? cfg_stat_sel : ssel_q;
  wire [CRC_W-1:0] poly_c  = sop ? (cfg_poly_sel ? poly_b : poly_a) : poly_q;
  wire [CRC_W-1:0] crc_c   = sop ? '1 : crc_q;
  wire [CRC_W-1:0] rx_c    = sop ? '0 : rx_q;

  wire in_rng = (idx_c >= start_c) && (tail_c ? !in_last : (idx_c <= end_c));
  wire [IDX_W:0] fld_off = {1'b0, idx_c} - {1'b0, pos_c};
  wire in_fld = (idx_c >= pos_c) && (fld_off < (IDX_W+1)'(NB));
  wire short_pkt = idx_c < start_c;

  logic [7:0] byte_m;
  always_comb
    for (int b = 0; b < 8; b++)
      byte_m[b] = mir_c ? in_data[7-b] : in_data[b];

  wire [7:0] feed = in_fld ? 8'h00 : byte_m;

  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                input logic [7:0] d,
                                                input logic [CRC_W-1:0] p);
    logic [CRC_W-1:0] r;
    r = c ^ (CRC_W'(d) << (CRC_W - 8));
    for (int i = 0; i < 8; i++)
      r = r[CRC_W-1] ? ((r << 1) ^ p) : (r << 1);
    return r;
  endfunction

  wire [CRC_W-1:0] crc_n = (in_valid && in_rng) ? crc_step(crc_c, feed, poly_c) : crc_c;

  logic [CRC_W-1:0] rx_n;
  always_comb begin
    rx_n = rx_c;
    for (int k = 0; k < NB; k++)
      if (in_valid && in_fld && fld_off == (IDX_W+1)'(k))
        rx_n[CRC_W-1-8*k -: 8] = in_data;
  end

  wire [CRC_W-1:0] fin  = inv_c ? ~crc_n : crc_n;
  wire             pass = (fin == rx_n) && !short_pkt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_pkt     <= 1'b0;
      idx_q      <= '0;
      crc_q      <= '1;
      rx_q       <= '0;
      start_q    <= '0;
      end_q      <= '0;
      pos_q      <= '0;
      tail_q     <= 1'b0;
      mir_q      <= 1'b0;
      inv_q      <= 1'b0;
      ssel_q     <= 1'b0;
      poly_q     <= '0;
      res_valid  <= 1'b0;
      res_pass   <= 1'b0;
      res_status <= 1'b0;
    end else begin
      res_valid <= in_valid & in_last;
      if (in_valid) begin
        in_pkt <= ~in_last;
        idx_q  <= idx_c + 1'b1;
        crc_q  <= crc_n;
        rx_q   <= rx_n;
        if (in_last) begin
          res_pass   <= pass;
          res_status <= ssel_c ? pass : csum_ok;
        end
      end
      if (sop) begin
        start_q <= cfg_start;
        end_q   <= cfg_end;
        pos_q   <= cfg_crc_pos;
        tail_q  <= cfg_tail;
        mir_q   <= cfg_mirror;
        inv_q   <= cfg_invert;
        ssel_q  <= cfg_stat_sel;
        poly_q  <= cfg_poly_sel ? poly_b : poly_a;
      end
    end
  end

  // R2
  res_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(in_valid && in_last));

  // R2
  no_res_midpkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_last) |=> !res_valid);

  // R9
  csum_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_last && !ssel_c) |=> (res_status == $past(csum_ok)));

  // R11
  short_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_last && short_pkt) |=> !res_pass);

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(crc_q) && $stable(idx_q) && $stable(rx_q)));
endmodule

// File: tb/crc_check_test.sv
module crc_check_test;
  localparam int CLK = 4;
  logic clk = 0, rst_n = 0;
  always #(CLK/2) clk = ~clk;

  logic        in_valid = 0, in_last = 0;
  logic [7:0]  in_data = 0;
  logic [7:0]  cfg_start = 0;
  logic [15:0] cfg_end = 0, cfg_crc_pos = 0;
  logic        cfg_poly_sel = 0, cfg_mirror = 0, cfg_invert = 0, cfg_tail = 0, cfg_stat_sel = 0;
  logic [31:0] poly_a = 32'h04C11DB7, poly_b = 32'h1EDC6F41;
  logic        csum_ok = 0;
  logic        res_valid, res_pass, res_status;

  crc_check uut (.*);

  int compared = 0, mismatched = 0;
  logic [7:0] pkt [0:31];
  int plen;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_crc();
    logic [31:0] c = '1;
    logic [31:0] p = cfg_poly_sel ? poly_b : poly_a;
    for (int i = 0; i < plen; i++) begin
      logic cov;
      logic [7:0] d;
      cov = (i >= cfg_start) && (cfg_tail ? (i < plen - 1) : (i <= cfg_end));
      if (!cov) continue;
      d = pkt[i];
      if (cfg_mirror) d = {<<{d}};
      if (i >= cfg_crc_pos && i < cfg_crc_pos + 4) d = 8'h00;
      for (int k = 7; k >= 0; k--) begin
        logic fb;
        fb = c[31] ^ d[k];
        c = {c[30:0], 1'b0};
        if (fb) c = c ^ p;
      end
    end
    return cfg_invert ? ~c : c;
  endfunction

  function automatic logic [31:0] model_rx();
    logic [31:0] r = '0;
    for (int k = 0; k < 4; k++)
      if (cfg_crc_pos + k < plen) r[31-8*k -: 8] = pkt[cfg_crc_pos + k];
    return r;
  endfunction

  task automatic send_check(string req, logic gaps);
    logic exp_pass, exp_stat;
    logic [7:0] s_start; logic [15:0] s_end, s_pos;
    logic s_ps, s_mi, s_in, s_ta, s_ss;
    exp_pass = (model_crc() == model_rx()) && (plen > cfg_start);
    exp_stat = cfg_stat_sel ? exp_pass : csum_ok;
    s_start = cfg_start; s_end = cfg_end; s_pos = cfg_crc_pos;
    s_ps = cfg_poly_sel; s_mi = cfg_mirror; s_in = cfg_invert; s_ta = cfg_tail; s_ss = cfg_stat_sel;
    for (int i = 0; i < plen; i++) begin
      @(negedge clk);
      in_valid = 1; in_data = pkt[i]; in_last = (i == plen - 1);
      if (i == 1) begin // R10: scramble settings after the first byte
        cfg_start = ~s_start; cfg_end = ~s_end; cfg_crc_pos = ~s_pos;
        cfg_poly_sel = ~s_ps; cfg_mirror = ~s_mi; cfg_invert = ~s_in;
        cfg_tail = ~s_ta; cfg_stat_sel = ~s_ss;
      end
      if (gaps && (i % 4 == 1) && i != plen - 1) begin // R12
        @(negedge clk); in_valid = 0;
      end
    end
    @(negedge clk);
    in_valid = 0; in_last = 0;
    chk({req, " valid"}, res_valid, 1);
    chk({req, " pass"}, res_pass, exp_pass);
    chk({req, " status R9"}, res_status, exp_stat);
    @(negedge clk);
    chk("R2 pulse", res_valid, 0);
    cfg_start = s_start; cfg_end = s_end; cfg_crc_pos = s_pos;
    cfg_poly_sel = s_ps; cfg_mirror = s_mi; cfg_invert = s_in; cfg_tail = s_ta; cfg_stat_sel = s_ss;
  endtask

  task automatic fill(int len, int seed);
    plen = len;
    for (int i = 0; i < len; i++) pkt[i] = 8'((i * 37 + seed * 11 + 5) ^ (seed << 3));
  endtask

  task automatic place_crc();
    logic [31:0] c;
    c = model_crc();
    for (int k = 0; k < 4; k++)
      if (cfg_crc_pos + k < plen) pkt[cfg_crc_pos + k] = c[31-8*k -: 8];
  endtask

  initial begin
    #(CLK * 150000);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 valid", res_valid, 0);
    chk("R1 pass", res_pass, 0);
    chk("R1 status", res_status, 0);
    rst_n = 1;
    for (int cfg = 0; cfg < 32; cfg++)
      for (int shape = 0; shape < 4; shape++) begin
        int len;
        len = (shape[0]) ? 20 : 12;
        cfg_tail = cfg[0]; cfg_poly_sel = cfg[1]; cfg_mirror = cfg[2];
        cfg_invert = cfg[3]; cfg_stat_sel = cfg[4];
        csum_ok = cfg[1] ^ cfg[3] ^ shape[0];
        cfg_start = shape[1] ? 8'd3 : 8'd0;
        fill(len, cfg + shape);
        if (shape[1]) begin // R4: field inside region
          cfg_crc_pos = 16'(cfg_start + 2);
          cfg_end = 16'(len - 1);
        end else begin // R3: field after region
          cfg_crc_pos = 16'(len - 4);
          cfg_end = 16'(len - 5);
        end
        if (cfg_tail) begin // R5: end value must be ignored
          cfg_crc_pos = 16'(len - 5);
          cfg_end = 16'd1;
        end
        place_crc();
        send_check("R2 R6 R7 R8 match", cfg[2]);
        pkt[cfg_start + 1] = pkt[cfg_start + 1] ^ 8'h10;
        send_check("R2 corrupt", !cfg[2]);
        if (!cfg_tail) begin // R3: byte beyond end has no effect
          fill(len, cfg);
          cfg_crc_pos = 16'(len - 4); cfg_end = 16'(len - 6);
          place_crc();
          pkt[len - 5] = ~pkt[len - 5];
          send_check("R3 outside", 0);
        end
      end
    // R11: packet ends before start offset
    cfg_tail = 0; cfg_start = 8'd10; cfg_end = 16'd20; cfg_crc_pos = 16'd0;
    cfg_invert = 1; cfg_stat_sel = 1;
    for (int l = 1; l <= 10; l++) begin
      fill(l, l);
      pkt[0] = 0; pkt[1] = 0; pkt[2] = 0; pkt[3] = 0;
      if (l >= 4) begin pkt[0] = 0; end
      send_check("R11 short", l[0]);
      chk("R11 fail", res_pass, 0);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule